// File: doc/BRIEF.md
# Hot-Plug Driven Port Selector

This block is the control logic of a display switch with one upstream input and two downstream ports, A and B. Each downstream port reports its attachment through a hot-plug line. From those two lines, a priority input and an active-low low-power input, the block decides which port is connected and whether the data path drives or floats. It exports a port select, a port-valid flag and a data-path enable for the analog multiplexer. It also drives a hot-plug line and a cable-adapter-detect line back toward the source.

A change of port is never a plain multiplexer flip. Before the block moves to the preferred port, it holds the upstream hot-plug line low for a fixed interval (T2). The source sees this as an unplug and later a replug. A selected line that stays low for T2 is treated as a disconnect. A priority change is accepted only after it has stayed stable for a settling interval (T1). T1 and T2 are parameters counted in clock cycles. They are nominally about 2 ms (at most 4.7 ms) and in the 170 to 400 ms range respectively.

Top module: `hpd_port_sel`

## Requirements
- R1: After synchronous reset, hpdOut, portValid, portSel, pathEn and cadOut are all 0.
- R2: With exactly one hot-plug input high, that port is selected (portSel 0 = A, 1 = B), portValid is 1 and hpdOut follows that input, whatever the priority level.
- R3: When both hot-plug inputs rise together out of low power, prioB = 1 selects port B and prioB = 0 selects port A.
- R4: pathEn is 1 only when a port is selected and lpN is high. With lpN low a port is still selected and hpdOut still follows it.
- R5: A low pulse on the selected hot-plug input that is shorter than T2 cycles appears on hpdOut with the same length in cycles, and the selection does not change.
- R6: When the selected hot-plug input stays low for T2 cycles, the block selects the other port if that port's input is high. Otherwise it enters low power, with portValid 0 and pathEn 0.
- R7: When the preferred port's hot-plug input rises while the other port is selected, hpdOut is held low for exactly T2 cycles and then portSel moves to the preferred port.
- R8: If the preferred port's input drops during that forced-low interval, the interval restarts once it returns. hpdOut then stays low for at least the elapsed time, plus the drop, plus T2.
- R9: With both inputs high, a priority change that reverts within T1 cycles has no effect: hpdOut never goes low and portSel is unchanged.
- R10: With both inputs high, a priority change held longer than T1 produces a forced low of exactly T2 cycles on hpdOut, after which portSel matches the new priority.
- R11: cadOut equals the selected port's cable-adapter-detect input and is 0 when no port is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hpdA | input | 1 | Hot-plug input from port A (asynchronous) |
| hpdB | input | 1 | Hot-plug input from port B (asynchronous) |
| cadA | input | 1 | Cable-adapter-detect input from port A |
| cadB | input | 1 | Cable-adapter-detect input from port B |
| prioB | input | 1 | Priority: 1 prefers port B, 0 prefers port A |
| lpN | input | 1 | Low-power request, active low |
| hpdOut | output | 1 | Hot-plug line toward the source |
| cadOut | output | 1 | Forwarded cable-adapter-detect of the selected port |
| portSel | output | 1 | Selected port, 0 = A, 1 = B |
| portValid | output | 1 | A port is selected |
| pathEn | output | 1 | Data path driven (1) or high impedance (0) |

## Verification
The assertions assume that every input holds a level for at least as many cycles as the synchronizer is deep. They also assume that the hot-plug lines of A and B are seen in the same synchronized cycle when they change together, so entry from low power with both lines high resolves by priority. The stimulus changes inputs only on falling clock edges and holds each level for several cycles. Glitch tests therefore measure the T1 window rather than metastability. Pulse lengths are chosen well below or well above T2 and T1, so each expected outcome does not depend on the pipeline delay.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    ST_LOWPWR = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SETTLE = 2'd2,
    ST_FORCE  = 2'd3
  } selState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic valid;
    logic sel;
    logic forceLow;
  } selStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[STAGES-2:0], din[b]};
    end
    assign dout[b] = pipe[STAGES-1];
  end

endmodule

// File: rtl/hps_ctrl.sv
module hps_ctrl
  import hps_pkg::*;
#(
  parameter int T1_CYC = 200_000,
  parameter int T2_CYC = 25_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hpdA,
  input  logic       hpdB,
  input  logic       prioB,
  output selStrobe_t strobe
);

  localparam int CNT_MAX = maxOf(T1_CYC, T2_CYC);
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] T1M1 = CW'(T1_CYC - 1);
  localparam logic [CW-1:0] T2M1 = CW'(T2_CYC - 1);

  selState_t     st;
  logic          sel;
  logic          tgt;
  logic          prioSeen;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lowCnt;

  logic selHpd, othHpd, prefHpd, tgtHpd;

  always_comb begin
    selHpd  = sel      ? hpdB : hpdA;
    othHpd  = sel      ? hpdA : hpdB;
    prefHpd = prioSeen ? hpdB : hpdA;
    tgtHpd  = tgt      ? hpdB : hpdA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_LOWPWR;
      sel      <= 1'b0;
      tgt      <= 1'b0;
      prioSeen <= 1'b0;
      cnt      <= '0;
      lowCnt   <= '0;
    end else begin
      case (st)
        ST_LOWPWR: begin
          cnt      <= '0;
          lowCnt   <= '0;
          prioSeen <= prioB;
          if (hpdA || hpdB) begin
            st  <= ST_ACTIVE;
            sel <= (hpdA && hpdB) ? prioB : hpdB;
          end
        end
        ST_ACTIVE: begin
          if (!selHpd && lowCnt == T2M1) begin
            lowCnt <= '0;
            if (othHpd) sel <= ~sel;
            else        st  <= ST_LOWPWR;
          end else begin
            lowCnt <= selHpd ? '0 : lowCnt + 1'b1;
            if (prioB != prioSeen) begin
              if (hpdA && hpdB) begin
                st  <= ST_SETTLE;
                cnt <= '0;
              end else begin
                prioSeen <= prioB;
              end
            end else if (prefHpd && (prioSeen != sel)) begin
              st  <= ST_FORCE;
              tgt <= prioSeen;
              cnt <= '0;
            end
          end
        end
        ST_SETTLE: begin
          lowCnt <= '0;
          if (prioB == prioSeen) begin
            st <= ST_ACTIVE;
          end else if (cnt == T1M1) begin
            prioSeen <= prioB;
            st       <= ST_ACTIVE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FORCE: begin
          if (!hpdA && !hpdB) begin
            st <= ST_LOWPWR;
          end else if (!tgtHpd) begin
            cnt <= '0;
          end else if (cnt == T2M1) begin
            sel    <= tgt;
            st     <= ST_ACTIVE;
            lowCnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_LOWPWR;
      endcase
    end
  end

  always_comb begin
    strobe.valid    = (st != ST_LOWPWR);
    strobe.sel      = sel;
    strobe.forceLow = (st == ST_FORCE);
  end

  // R9
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_SETTLE) |-> $stable(sel));

  // R7
  force_target_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACTIVE && $past(st) == ST_FORCE) |-> (sel == $past(tgt)));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CNT_MAX));

  // R6
  low_window_chk: assert property (@(posedge clk) disable iff (rst)
    lowCnt <= T2M1);

endmodule

// File: rtl/hps_dp.sv
module hps_dp
  import hps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  selStrobe_t strobe,
  input  logic       hpdA,
  input  logic       hpdB,
  input  logic       cadA,
  input  logic       cadB,
  input  logic       lpN,
  output logic       hpdOut,
  output logic       cadOut,
  output logic       portSel,
  output logic       portValid,
  output logic       pathEn
);

  logic hpdMux, cadMux;

  always_comb begin
    hpdMux = strobe.sel ? hpdB : hpdA;
    cadMux = strobe.sel ? cadB : cadA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpdOut    <= 1'b0;
      cadOut    <= 1'b0;
      portSel   <= 1'b0;
      portValid <= 1'b0;
      pathEn    <= 1'b0;
    end else begin
      hpdOut    <= strobe.valid && !strobe.forceLow && hpdMux;
      cadOut    <= strobe.valid && cadMux;
      portSel   <= strobe.valid && strobe.sel;
      portValid <= strobe.valid;
      pathEn    <= strobe.valid && lpN;
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.valid |=> (!hpdOut && !cadOut && !portValid));

  // R7
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.forceLow |=> !hpdOut);

  // R4
  lowpower_float_chk: assert property (@(posedge clk) disable iff (rst)
    !lpN |=> !pathEn);

endmodule

// File: rtl/hpd_port_sel.sv
module hpd_port_sel
  import hps_pkg::*;
#(
  parameter int T1_CYC      = 200_000,
  parameter int T2_CYC      = 25_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hpdA,
  input  logic hpdB,
  input  logic cadA,
  input  logic cadB,
  input  logic prioB,
  input  logic lpN,
  output logic hpdOut,
  output logic cadOut,
  output logic portSel,
  output logic portValid,
  output logic pathEn
);

  localparam int NIN = 6;

  logic [NIN-1:0] rawIn, synIn;
  selStrobe_t     strobe;

  assign rawIn = {cadB, cadA, lpN, prioB, hpdB, hpdA};

  hps_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rawIn),
    .dout(synIn)
  );

  hps_ctrl #(.T1_CYC(T1_CYC), .T2_CYC(T2_CYC)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .hpdA  (synIn[0]),
    .hpdB  (synIn[1]),
    .prioB (synIn[2]),
    .strobe(strobe)
  );

  hps_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .hpdA     (synIn[0]),
    .hpdB     (synIn[1]),
    .cadA     (synIn[4]),
    .cadB     (synIn[5]),
    .lpN      (synIn[3]),
    .hpdOut   (hpdOut),
    .cadOut   (cadOut),
    .portSel  (portSel),
    .portValid(portValid),
    .pathEn   (pathEn)
  );

endmodule

// File: tb/sim_hpd_port_sel.sv
`timescale 1ns/1ps
module sim_hpd_port_sel;

  localparam int T1 = 8;
  localparam int T2 = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hpdA = 0, hpdB = 0, cadA = 0, cadB = 0, prioB = 0, lpN = 1;
  logic hpdOut, cadOut, portSel, portValid, pathEn;

  int checks = 0;
  int errors = 0;
  int lowRun = 0;
  int lastLow = 0;

  always #4 clk = ~clk;

  hpd_port_sel #(.T1_CYC(T1), .T2_CYC(T2)) u0 (
    .clk(clk), .rst(rst), .hpdA(hpdA), .hpdB(hpdB), .cadA(cadA), .cadB(cadB),
    .prioB(prioB), .lpN(lpN), .hpdOut(hpdOut), .cadOut(cadOut),
    .portSel(portSel), .portValid(portValid), .pathEn(pathEn)
  );

  // low-run monitor on hpdOut
  always @(negedge clk) begin
    if (rst) lowRun = 0;
    else if (!hpdOut) lowRun++;
    else begin
      if (lowRun != 0) lastLow = lowRun;
      lowRun = 0;
    end
  end

  // {hpdA,hpdB,prioB,lpN,cadA,cadB | valid,sel,hpd,pathEn,cad}
  localparam logic [10:0] VEC [7] = '{
    11'b000111_00000,
    11'b101110_10111,
    11'b010111_11111,
    11'b010010_11100,
    11'b111101_11111,
    11'b110101_10110,
    11'b110010_10101
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic [5:0] v);
    @(negedge clk);
    rst = 1'b1;
    {hpdA, hpdB, prioB, lpN, cadA, cadB} = v;
    waitCyc(3);
    rst = 1'b0;
    lastLow = 0;
  endtask

  initial begin
    // R1: reset state
    doReset(6'b000100);
    chk("R1 hpdOut", hpdOut, 0);
    chk("R1 portValid", portValid, 0);
    chk("R1 pathEn", pathEn, 0);
    chk("R1 cadOut", cadOut, 0);

    // table walk: R2 R3 R4 R11
    for (int i = 0; i < 7; i++) begin
      doReset(VEC[i][10:5]);
      waitCyc(10);
      chk($sformatf("R2/R3 valid vec%0d", i), portValid, VEC[i][4]);
      if (VEC[i][4]) chk($sformatf("R2/R3 sel vec%0d", i), portSel, VEC[i][3]);
      chk($sformatf("R2 hpdOut vec%0d", i), hpdOut, VEC[i][2]);
      chk($sformatf("R4 pathEn vec%0d", i), pathEn, VEC[i][1]);
      chk($sformatf("R11 cadOut vec%0d", i), cadOut, VEC[i][0]);
    end

    // R5: short pulse passes with same width
    doReset(6'b100100);
    waitCyc(10);
    lastLow = 0;
    hpdA = 0; waitCyc(5); hpdA = 1; waitCyc(10);
    chk("R5 pulse width", lastLow, 5);
    chk("R5 sel kept", portSel, 0);
    chk("R5 valid kept", portValid, 1);

    // R6: long low with no other port -> low power
    hpdA = 0; waitCyc(T2 + 10);
    chk("R6 valid off", portValid, 0);
    chk("R6 pathEn off", pathEn, 0);
    hpdA = 1; waitCyc(10);
    chk("R2 reselect A", portValid, 1);
    chk("R2 hpd follows", hpdOut, 1);

    // R6: long low with other port high -> switch
    doReset(6'b110100);
    waitCyc(10);
    chk("R3 prio A", portSel, 0);
    hpdA = 0; waitCyc(T2 + 10);
    chk("R6 switched to B", portSel, 1);
    chk("R6 still valid", portValid, 1);
    chk("R6 hpd from B", hpdOut, 1);

    // R7: preferred port appears -> forced low T2 then switch
    doReset(6'b010100);
    waitCyc(10);
    lastLow = 0;
    hpdA = 1; waitCyc(T2 + 15);
    chk("R7 forced width", lastLow, T2);
    chk("R7 sel A", portSel, 0);
    chk("R7 hpd high", hpdOut, 1);

    // R8: dropout during forced low restarts countdown
    doReset(6'b010100);
    waitCyc(10);
    lastLow = 0;
    hpdA = 1; waitCyc(8);
    hpdA = 0; waitCyc(3);
    hpdA = 1; waitCyc(T2 + 20);
    chk("R8 restarted", (lastLow >= T2 + 3 + 5) ? 1 : 0, 1);
    chk("R8 sel A", portSel, 0);

    // R9: priority glitch shorter than T1 ignored
    doReset(6'b110100);
    waitCyc(10);
    lastLow = 0;
    prioB = 1; waitCyc(T1 / 2); prioB = 0; waitCyc(T2 + 20);
    chk("R9 no forced low", lastLow, 0);
    chk("R9 sel unchanged", portSel, 0);

    // R10: priority change held -> settle, force, switch
    lastLow = 0;
    prioB = 1; waitCyc(T1 + T2 + 20);
    chk("R10 forced width", lastLow, T2);
    chk("R10 sel B", portSel, 1);
    chk("R10 hpd high", hpdOut, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule